// File: doc/BRIEF.md
# Oblivious Mesh Route Computation

This block picks the output port of a two-dimensional mesh router for each packet, working only from coordinates and a few per-packet fields carried in the head flit. It never looks at buffer occupancy or link load. One of four algorithms is chosen per packet through a mode input. Dimension-ordered routing corrects X before Y. Turn-randomised routing picks X-first or Y-first per packet with equal odds. Random-waypoint routing first goes minimally to a random node anywhere in the mesh. Box-waypoint routing goes to a random node inside the rectangle spanned by source and destination, so the path stays minimal.

When a head flit enters the network at its source, the `inject` input is set. The block then draws the packet's random choices from an internal 16-bit LFSR and returns them on the `out_*` outputs, so they can be written back into the head flit. At later hops the same fields come back in on the `in_*` inputs. The block moves the packet from the waypoint leg to the final leg when the current node is the waypoint. Body flits reuse the port that was picked for the last head flit.

Top module: `mesh_route_unit`

## Requirements
- R1: `mode` selects the algorithm: 0 = dimension-ordered XY, 1 = turn-randomised XY/YX, 2 = random waypoint anywhere in the mesh, 3 = random waypoint inside the source/destination box.
- R2: `port_sel` is always one-hot, with bit 0 = local, bit 1 = east (+X), bit 2 = west (-X), bit 3 = north (+Y), bit 4 = south (-Y).
- R3: In XY order the port moves toward the target in X until X matches, then in Y. In YX order (`out_order`=1) Y is corrected first.
- R4: In mode 1 with `inject`=1, `out_order` equals LFSR bit 0. Without `inject` it equals `in_order`. All other modes report order 0. Modes 0 and 1 report `out_phase`=1 and a waypoint equal to the destination.
- R5: In mode 2 with `inject`=1, the waypoint is (LFSR[7:0] mod MESH_X, LFSR[15:8] mod MESH_Y) and the phase starts at 0. Without `inject`, `in_phase` and `in_mid_*` are used.
- R6: In mode 3 with `inject`=1, each waypoint coordinate is lo + r mod (hi-lo+1). Here lo and hi are the smaller and larger of the current and destination coordinate, and r is LFSR[7:0] for X and LFSR[15:8] for Y.
- R7: In phase 0, when the current node equals the waypoint, `out_phase` becomes 1 and the port is computed toward the destination in the same cycle.
- R8: In phase 1, when the current node equals the destination, the local port is selected.
- R9: A cycle with `flit_valid`=1 and `flit_head`=0, or with `flit_valid`=0, outputs the port chosen by the most recent head flit.
- R10: The LFSR starts from `LFSR_SEED` (0xACE1). Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. It advances exactly on clock edges where `flit_valid`, `flit_head` and `inject` are all 1.
- R11: After reset, and before any head flit, `port_sel` selects local.
- R12: A packet walked hop by hop reaches its destination in the Manhattan distance in modes 0, 1 and 3. In mode 2 it takes distance(source, waypoint) + distance(waypoint, destination).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | The present flit is a head flit |
| inject | input | 1 | Head flit is at its source router; draw fresh routing state |
| mode | input | 2 | Routing algorithm select |
| cur_x | input | XW | X coordinate of this router |
| cur_y | input | YW | Y coordinate of this router |
| dst_x | input | XW | Destination X from the head flit |
| dst_y | input | YW | Destination Y from the head flit |
| in_phase | input | 1 | Head-flit phase field (0 = heading to waypoint) |
| in_order | input | 1 | Head-flit order field (0 = XY, 1 = YX) |
| in_mid_x | input | XW | Head-flit waypoint X |
| in_mid_y | input | YW | Head-flit waypoint Y |
| port_sel | output | 5 | One-hot output port select |
| out_phase | output | 1 | Updated phase field to write into the head flit |
| out_order | output | 1 | Updated order field |
| out_mid_x | output | XW | Updated waypoint X |
| out_mid_y | output | YW | Updated waypoint Y |

## Verification
The hardest situation to reach from the ports is the leg change in the waypoint modes. It happens only when a packet already carrying phase 0 arrives at exactly the node it drew at injection. Random stimulus with independent fields almost never lines these up. So the bench walks whole packets through the mesh: it feeds each hop's `out_*` fields back as the next hop's `in_*` fields and moves the current node along the chosen port. Every walk is therefore forced through its waypoint and its destination, and the hop count is compared with the minimal or two-leg distance.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [1:0] {
    MODE_XY   = 2'd0,
    MODE_TURN = 2'd1,
    MODE_WAY  = 2'd2,
    MODE_BOX  = 2'd3
  } rt_mode_e;

  localparam int NPORT    = 5;
  localparam int P_LOCAL  = 0;
  localparam int P_EAST   = 1;
  localparam int P_WEST   = 2;
  localparam int P_NORTH  = 3;
  localparam int P_SOUTH  = 4;
  localparam int RND_W    = 16;
endpackage

// File: rtl/mr_lfsr.sv
module mr_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;

  // taps 16,14,13,11 (one-based)
  always_comb begin
    state_d = state_q;
    if (step) state_d = {state_q[W-2:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED[W-1:0];
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R10: a maximal-length LFSR seeded nonzero never reaches zero
  a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0);
endmodule

// File: rtl/mr_state.sv
module mr_state
  import mr_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int XW     = 2,
  parameter int YW     = 2
) (
  input  rt_mode_e          mode,
  input  logic              inject,
  input  logic [RND_W-1:0]  rnd,
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  input  logic              in_phase,
  input  logic              in_order,
  input  logic [XW-1:0]     in_mid_x,
  input  logic [YW-1:0]     in_mid_y,
  output logic              eff_phase,
  output logic              eff_order,
  output logic [XW-1:0]     eff_mid_x,
  output logic [YW-1:0]     eff_mid_y
);
  int rx, ry, lox, loy, spx, spy;
  logic [XW-1:0] way_x, box_x;
  logic [YW-1:0] way_y, box_y;

  always_comb begin
    rx  = int'(rnd[7:0]);
    ry  = int'(rnd[15:8]);
    lox = (cur_x < dst_x) ? int'(cur_x) : int'(dst_x);
    loy = (cur_y < dst_y) ? int'(cur_y) : int'(dst_y);
    spx = ((cur_x < dst_x) ? int'(dst_x) - int'(cur_x) : int'(cur_x) - int'(dst_x)) + 1;
    spy = ((cur_y < dst_y) ? int'(dst_y) - int'(cur_y) : int'(cur_y) - int'(dst_y)) + 1;
    way_x = XW'(rx % MESH_X);
    way_y = YW'(ry % MESH_Y);
    box_x = XW'(lox + rx % spx);
    box_y = YW'(loy + ry % spy);
  end

  always_comb begin
    eff_phase = 1'b1;
    eff_order = 1'b0;
    eff_mid_x = dst_x;
    eff_mid_y = dst_y;
    unique case (mode)
      MODE_XY: ;
      MODE_TURN: eff_order = inject ? rnd[0] : in_order;
      MODE_WAY: begin
        eff_phase = inject ? 1'b0 : in_phase;
        eff_mid_x = inject ? way_x : in_mid_x;
        eff_mid_y = inject ? way_y : in_mid_y;
      end
      MODE_BOX: begin
        eff_phase = inject ? 1'b0 : in_phase;
        eff_mid_x = inject ? box_x : in_mid_x;
        eff_mid_y = inject ? box_y : in_mid_y;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mr_port.sv
module mr_port
  import mr_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic              phase,
  input  logic              order,
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  input  logic [XW-1:0]     mid_x,
  input  logic [YW-1:0]     mid_y,
  output logic              new_phase,
  output logic [NPORT-1:0]  port
);
  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;
  logic [NPORT-1:0] x_port, y_port;

  always_comb begin
    new_phase = phase | ((cur_x == mid_x) && (cur_y == mid_y));
    tgt_x = new_phase ? dst_x : mid_x;
    tgt_y = new_phase ? dst_y : mid_y;

    x_port = '0;
    if (tgt_x > cur_x)      x_port[P_EAST] = 1'b1;
    else if (tgt_x < cur_x) x_port[P_WEST] = 1'b1;

    y_port = '0;
    if (tgt_y > cur_y)      y_port[P_NORTH] = 1'b1;
    else if (tgt_y < cur_y) y_port[P_SOUTH] = 1'b1;

    port = '0;
    if (!order) port = (x_port != '0) ? x_port : y_port;
    else        port = (y_port != '0) ? y_port : x_port;
    if (port == '0) port[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mr_pkg::*;
#(
  parameter int          MESH_X    = 4,
  parameter int          MESH_Y    = 4,
  parameter int          XW        = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  parameter int          YW        = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic              flit_head,
  input  logic              inject,
  input  logic [1:0]        mode,
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  input  logic              in_phase,
  input  logic              in_order,
  input  logic [XW-1:0]     in_mid_x,
  input  logic [YW-1:0]     in_mid_y,
  output logic [4:0]        port_sel,
  output logic              out_phase,
  output logic              out_order,
  output logic [XW-1:0]     out_mid_x,
  output logic [YW-1:0]     out_mid_y
);
  logic [RND_W-1:0] rnd;
  logic             head_now, draw_en;
  logic             eff_phase;
  logic [NPORT-1:0] calc_port, route_q, route_d;
  rt_mode_e         mode_e;

  assign mode_e   = rt_mode_e'(mode);
  assign head_now = flit_valid & flit_head;
  assign draw_en  = head_now & inject;

  mr_lfsr #(.W(RND_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(draw_en), .state(rnd)
  );

  mr_state #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW)) u_state (
    .mode(mode_e), .inject(inject), .rnd(rnd),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .in_phase(in_phase), .in_order(in_order), .in_mid_x(in_mid_x), .in_mid_y(in_mid_y),
    .eff_phase(eff_phase), .eff_order(out_order), .eff_mid_x(out_mid_x), .eff_mid_y(out_mid_y)
  );

  mr_port #(.XW(XW), .YW(YW)) u_port (
    .phase(eff_phase), .order(out_order),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .mid_x(out_mid_x), .mid_y(out_mid_y),
    .new_phase(out_phase), .port(calc_port)
  );

  // held route for body flits
  always_comb begin
    route_d = route_q;
    if (head_now) route_d = calc_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= NPORT'(1) << P_LOCAL;
    else        route_q <= route_d;
  end

  assign port_sel = head_now ? calc_port : route_q;

  // R2: exactly one port at all times
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot(port_sel));

  // R8: local only once the destination is reached
  a_r8_local_at_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (head_now && port_sel[P_LOCAL]) |-> (cur_x == dst_x && cur_y == dst_y));

  // R9: a body flit right after a head flit keeps that head's port
  a_r9_body_hold: assert property (@(posedge clk) disable iff (!rst_n)
    head_now ##1 (flit_valid && !flit_head) |-> port_sel == $past(port_sel));

  // R6: box waypoint lies between source and destination
  a_r6_in_box: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_en && mode == 2'd3) |->
      (out_mid_x >= ((cur_x < dst_x) ? cur_x : dst_x)) &&
      (out_mid_x <= ((cur_x < dst_x) ? dst_x : cur_x)) &&
      (out_mid_y >= ((cur_y < dst_y) ? cur_y : dst_y)) &&
      (out_mid_y <= ((cur_y < dst_y) ? dst_y : cur_y)));

  // R7: arriving at the waypoint switches to the final leg
  a_r7_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (head_now && !inject && mode[1] && !in_phase && cur_x == in_mid_x && cur_y == in_mid_y)
      |-> out_phase);
endmodule

// File: tb/sim_mesh_route_unit.sv
module sim_mesh_route_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic flit_valid, flit_head, inject;
  logic [1:0] mode;
  logic [1:0] cur_x, cur_y, dst_x, dst_y, in_mid_x, in_mid_y;
  logic in_phase, in_order;
  logic [4:0] port_sel;
  logic out_phase, out_order;
  logic [1:0] out_mid_x, out_mid_y;

  int checks = 0;
  int fails  = 0;
  int model_lfsr;
  int model_held;
  bit done = 0;

  always #4 clk = ~clk;

  mesh_route_unit u0 (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
    .inject(inject), .mode(mode), .cur_x(cur_x), .cur_y(cur_y),
    .dst_x(dst_x), .dst_y(dst_y), .in_phase(in_phase), .in_order(in_order),
    .in_mid_x(in_mid_x), .in_mid_y(in_mid_y), .port_sel(port_sel),
    .out_phase(out_phase), .out_order(out_order),
    .out_mid_x(out_mid_x), .out_mid_y(out_mid_y)
  );

  function automatic int iabs(int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic int next_lfsr(int s);
    int fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) & 16'hFFFE) | fb;
  endfunction

  // Behavioural model of R1..R8: returns expected port index and state
  task automatic model(input int md, inj, cx, cy, dx, dy, ip, io, imx, imy,
                       output int port, ph, od, mx, my);
    int rx, ry, tx, ty, lo;
    rx = model_lfsr & 255;
    ry = (model_lfsr >> 8) & 255;
    ph = 1; od = 0; mx = dx; my = dy;
    if (md == 1) od = inj ? (model_lfsr & 1) : io;
    if (md == 2) begin
      ph = inj ? 0 : ip;
      mx = inj ? rx % 4 : imx;
      my = inj ? ry % 4 : imy;
    end
    if (md == 3) begin
      ph = inj ? 0 : ip;
      lo = (cx < dx) ? cx : dx;
      mx = inj ? lo + rx % (iabs(cx - dx) + 1) : imx;
      lo = (cy < dy) ? cy : dy;
      my = inj ? lo + ry % (iabs(cy - dy) + 1) : imy;
    end
    if (ph == 0 && cx == mx && cy == my) ph = 1;
    tx = ph ? dx : mx;
    ty = ph ? dy : my;
    port = 0;
    if (od == 0) begin
      if (tx > cx) port = 1; else if (tx < cx) port = 2;
      else if (ty > cy) port = 3; else if (ty < cy) port = 4;
    end else begin
      if (ty > cy) port = 3; else if (ty < cy) port = 4;
      else if (tx > cx) port = 1; else if (tx < cx) port = 2;
    end
  endtask

  // One clock: drive at negedge, check before posedge, update model at posedge
  task automatic cycle(input int v, h, inj, md, cx, cy, dx, dy, ip, io, imx, imy,
                       input string tag);
    int p, ph, od, mx, my, exp_sel;
    flit_valid = v[0]; flit_head = h[0]; inject = inj[0]; mode = md[1:0];
    cur_x = cx[1:0]; cur_y = cy[1:0]; dst_x = dx[1:0]; dst_y = dy[1:0];
    in_phase = ip[0]; in_order = io[0]; in_mid_x = imx[1:0]; in_mid_y = imy[1:0];
    #1;
    model(md, inj, cx, cy, dx, dy, ip, io, imx, imy, p, ph, od, mx, my);
    exp_sel = (v && h) ? (1 << p) : model_held;
    checks++;
    if (int'(port_sel) != exp_sel || int'(out_phase) != ph || int'(out_order) != od ||
        int'(out_mid_x) != mx || int'(out_mid_y) != my) begin
      fails++;
      $display("FAIL %s: port=%b ph=%0d ord=%0d mid=(%0d,%0d) expected port=%b ph=%0d ord=%0d mid=(%0d,%0d)",
               tag, port_sel, out_phase, out_order, out_mid_x, out_mid_y,
               exp_sel[4:0], ph, od, mx, my);
    end
    @(posedge clk);
    if (v && h) begin
      model_held = 1 << p;
      if (inj) model_lfsr = next_lfsr(model_lfsr);  // R10
    end
    @(negedge clk);
  endtask

  // Walk one packet from source to destination (R3, R7, R8, R9, R12)
  task automatic walk(input int md, sx, sy, dx, dy, input string tag);
    int cx, cy, ph, od, mx, my, hops, p, expect_hops, first;
    cx = sx; cy = sy; ph = 0; od = 0; mx = 0; my = 0; hops = 0; first = 1;
    expect_hops = iabs(sx - dx) + iabs(sy - dy);
    while (hops < 20) begin
      cycle(1, 1, first, md, cx, cy, dx, dy, ph, od, mx, my, tag);
      p = 0;
      for (int i = 0; i < 5; i++) if (port_sel[i]) p = i;
      ph = out_phase; od = out_order; mx = out_mid_x; my = out_mid_y;
      if (first && md == 2)
        expect_hops = iabs(sx - mx) + iabs(sy - my) + iabs(mx - dx) + iabs(my - dy);
      first = 0;
      cycle(1, 0, 0, md, cx, cy, dx, dy, ph, od, mx, my, {tag, " R9 body"});
      if (p == 0) break;
      if (p == 1) cx++; else if (p == 2) cx--; else if (p == 3) cy++; else cy--;
      hops++;
    end
    checks++;
    if (hops != expect_hops || cx != dx || cy != dy) begin
      fails++;
      $display("FAIL R12 %s: hops=%0d at (%0d,%0d) expected hops=%0d at (%0d,%0d)",
               tag, hops, cx, cy, expect_hops, dx, dy);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    flit_valid = 0; flit_head = 0; inject = 0; mode = 0;
    cur_x = 0; cur_y = 0; dst_x = 0; dst_y = 0;
    in_phase = 0; in_order = 0; in_mid_x = 0; in_mid_y = 0;
    model_lfsr = 16'hACE1;
    model_held = 1;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (port_sel != 5'b00001) begin  // R11
      fails++;
      $display("FAIL R11 reset: port=%b expected 00001", port_sel);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cycle(0, 0, 0, 0, 1, 1, 3, 3, 0, 0, 0, 0, "R11 idle after reset");

    // R3 XY: x first then y
    cycle(1, 1, 0, 0, 0, 0, 2, 3, 1, 0, 0, 0, "R3 xy east");
    cycle(1, 1, 0, 0, 2, 0, 2, 3, 1, 0, 0, 0, "R3 xy north");
    cycle(1, 1, 0, 0, 3, 3, 0, 0, 1, 0, 0, 0, "R3 xy west");
    cycle(1, 1, 0, 0, 2, 2, 2, 2, 1, 0, 0, 0, "R8 local");
    // R4 YX from field
    cycle(1, 1, 0, 1, 3, 3, 0, 0, 1, 1, 0, 0, "R4 yx south");
    // R9 idle/body hold
    cycle(0, 0, 0, 0, 0, 0, 3, 3, 0, 0, 0, 0, "R9 idle hold");
    // R7 phase advance at waypoint, both waypoint modes
    cycle(1, 1, 0, 2, 1, 2, 3, 0, 0, 0, 1, 2, "R7 way advance");
    cycle(1, 1, 0, 3, 1, 1, 1, 1, 0, 0, 1, 1, "R7 box advance local");
    // R5/R6/R4 injection draws
    cycle(1, 1, 1, 2, 0, 0, 3, 3, 0, 0, 0, 0, "R5 way draw");
    cycle(1, 1, 1, 3, 3, 0, 1, 2, 0, 0, 0, 0, "R6 box draw");
    cycle(1, 1, 1, 1, 0, 0, 3, 3, 0, 0, 0, 0, "R4 turn draw");
    // R10 inject without head does not advance LFSR
    cycle(1, 0, 1, 2, 0, 0, 3, 3, 0, 0, 0, 0, "R10 no step body");
    cycle(1, 1, 1, 2, 0, 0, 3, 3, 0, 0, 0, 0, "R10 draw after body");

    // whole-packet walks over every mode (R1, R12)
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 12; k++) begin
        walk(md, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, "R1 walk");
      end
    end

    // random mixed stimulus (R2, R5, R6, R9, R10)
    for (int k = 0; k < 400; k++) begin
      cycle($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4,
            $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
            $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4, "R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule